// File: doc/BRIEF.md
# Autonegotiation Config Word and Link Timer

This block sits beside the receive and transmit paths of a gigabit serial Ethernet PCS. From two mode inputs it selects the 16-bit configuration word that the transmitter sends during autonegotiation. One input chooses 1000BASE-X or SGMII, and the other chooses the MAC or PHY side. The same block also runs the autonegotiation link timer. The timer interval depends on the mode: 10 ms for 1000BASE-X and 1.6 ms for SGMII.

The timer counts in coarse units of 1024 system clocks. A free-running prescaler produces one tick per unit, and the main counter advances only on ticks. The terminal count is derived from the system clock frequency parameter `CLK_MHZ`. A configuration override input can replace it with a programmed value. A restart command, or any change of either mode input, clears the prescaler and the counter and starts a new interval. When the interval ends, the block raises a one-cycle expiry pulse. It then holds until the next restart.

The control is a four-state machine:
- `ST_IDLE`: after reset, nothing is counting.
- `ST_RUN`: counting.
- `ST_FIRE`: the single expiry cycle.
- `ST_HOLD`: the interval has elapsed, waiting for a restart.

Transitions:
- Any state goes to `ST_RUN` on a kick (a restart or a mode change).
- `ST_RUN` goes to `ST_FIRE` on the tick that reaches the terminal count.
- `ST_FIRE` goes to `ST_HOLD` unconditionally.
- Otherwise the state is kept.

Top module: `an_cfg_link_timer`

## Requirements
- R1: In 1000BASE-X mode (`mode_basex`=1), `cfg_word` is 0x01E0, whatever the value of `side_phy`. Bit 5 is full duplex = 1, bit 6 is half duplex = 1, bits 8:7 are pause = 11, bits 13:12 are remote fault = 00, and all other bits are 0.
- R2: In SGMII MAC mode (`mode_basex`=0, `side_phy`=0), `cfg_word` is the fixed value 0x4001.
- R3: In SGMII PHY mode (`mode_basex`=0, `side_phy`=1), `cfg_word` is 0x9801. Bit 15 is link up = 1, bit 12 is full duplex = 1, bits 11:10 are speed = 10 (1000 Mb/s), bit 0 is 1, and all other bits are 0.
- R4: The terminal count T is (10000 × `CLK_MHZ`) >> 10 in 1000BASE-X mode and (1600 × `CLK_MHZ`) >> 10 in SGMII mode. Let E be the rising edge that captures a kick. `tmr_expired` is high in the cycle that follows edge E + 1024·T.
- R5: While `cnt_ovr_en`=1, T is `cnt_ovr_val` instead of the computed value. A value of 0 behaves as 1.
- R6: `tmr_expired` lasts exactly one cycle. After it, `tmr_running` is low and no further pulse appears until the next kick.
- R7: `tmr_running` is high from edge E until edge E + 1024·T, and never in the same cycle as `tmr_expired`.
- R8: A `restart` during a run discards the elapsed time. The full interval is measured again from the new capture edge.
- R9: A change of `mode_basex` or `side_phy` acts as a restart: the timer clears and starts in the same edge that sees the change.
- R10: After reset, the timer is idle: `tmr_running`=0 and `tmr_expired`=0 until the first kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_basex | input | 1 | 1 = 1000BASE-X, 0 = SGMII |
| side_phy | input | 1 | In SGMII: 1 = PHY side, 0 = MAC side |
| restart | input | 1 | Starts a new link timer interval |
| cnt_ovr_en | input | 1 | Selects the programmed terminal count |
| cnt_ovr_val | input | CNT_W | Programmed terminal count in 1024-clock units |
| cfg_word | output | 16 | Transmit configuration word |
| tmr_expired | output | 1 | One-cycle pulse at the end of the interval |
| tmr_running | output | 1 | High while the interval is being timed |

## Verification
A wrong prescaler phase or a counter that is not cleared moves the expiry pulse by up to 1024 cycles per unit. The bench therefore compares the exact edge of every pulse against the value it predicts from the kick edge. A state machine that leaves `ST_FIRE` late, or that re-enters the run state, shows up as a second pulse. That pulse is reported the moment it appears, because the expectation queue is then empty. Errors in the configuration word selection show at the port at once, in the same cycle the mode inputs settle.

// File: rtl/an_timer_pkg.sv
package an_timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2,
        ST_HOLD = 2'd3
    } tmr_state_t;

    localparam int unsigned PRE_W     = 10;
    localparam int unsigned BASEX_US  = 10000;
    localparam int unsigned SGMII_US  = 1600;

    localparam logic [15:0] WORD_SGMII_MAC = 16'h4001;

    // 1000BASE-X ability fields
    localparam int unsigned BX_FD_BIT    = 5;
    localparam int unsigned BX_HD_BIT    = 6;
    localparam int unsigned BX_PAUSE_LSB = 7;
    localparam int unsigned BX_RF_LSB    = 12;

    // SGMII PHY-side fields
    localparam int unsigned SG_SPD_LSB  = 10;
    localparam int unsigned SG_DUP_BIT  = 12;
    localparam int unsigned SG_LINK_BIT = 15;

    function automatic int unsigned units_for(input int unsigned us, input int unsigned mhz);
        return (us * mhz) >> PRE_W;
    endfunction

endpackage

// File: rtl/an_cfg_word_sel.sv
module an_cfg_word_sel
    import an_timer_pkg::*;
(
    input  logic        mode_basex,
    input  logic        side_phy,
    output logic [15:0] word
);
    logic [15:0] basex_w;
    logic [15:0] phy_w;

    always_comb begin
        basex_w = '0;
        basex_w[BX_FD_BIT]                   = 1'b1;
        basex_w[BX_HD_BIT]                   = 1'b1;
        basex_w[BX_PAUSE_LSB +: 2]           = 2'b11;
        basex_w[BX_RF_LSB +: 2]              = 2'b00;

        phy_w = '0;
        phy_w[0]                             = 1'b1;
        phy_w[SG_SPD_LSB +: 2]               = 2'b10;
        phy_w[SG_DUP_BIT]                    = 1'b1;
        phy_w[SG_LINK_BIT]                   = 1'b1;
    end

    always_comb begin
        unique case ({mode_basex, side_phy})
            2'b10, 2'b11: word = basex_w;
            2'b01:        word = phy_w;
            2'b00:        word = WORD_SGMII_MAC;
            default:      word = WORD_SGMII_MAC;
        endcase
    end
endmodule

// File: rtl/an_prescaler.sv
module an_prescaler #(
    parameter int unsigned PW = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    logic [PW-1:0] pre;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pre <= '0;
        else if (clr) pre <= '0;
        else if (run) pre <= pre + 1'b1;
    end

    assign tick = run && (pre == {PW{1'b1}});

    // R8 / R9: a kick leaves the prescaler at zero
    a_r8_pre_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre == '0));
    // prescaler only moves while running
    a_r6_pre_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !run) |=> $stable(pre));
endmodule

// File: rtl/an_timer_fsm.sv
module an_timer_fsm
    import an_timer_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kick,
    input  logic          tick,
    input  logic [CW-1:0] term,
    output logic          running,
    output logic          expired
);
    tmr_state_t    state, state_nx;
    logic [CW-1:0] cnt;
    logic [CW:0]   cnt_inc;
    logic [CW:0]   term_eff;
    logic          reach;

    assign cnt_inc  = {1'b0, cnt} + 1'b1;
    assign term_eff = (term == '0) ? {{CW{1'b0}}, 1'b1} : {1'b0, term};
    assign reach    = tick && (cnt_inc >= term_eff);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = kick ? ST_RUN : ST_IDLE;
            ST_RUN:  state_nx = kick ? ST_RUN : (reach ? ST_FIRE : ST_RUN);
            ST_FIRE: state_nx = kick ? ST_RUN : ST_HOLD;
            ST_HOLD: state_nx = kick ? ST_RUN : ST_HOLD;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       cnt <= '0;
        else if (kick)                    cnt <= '0;
        else if (state == ST_RUN && tick) cnt <= cnt_inc[CW-1:0];
    end

    always_comb begin
        running = 1'b0;
        expired = 1'b0;
        unique case (state)
            ST_RUN:  running = 1'b1;
            ST_FIRE: expired = 1'b1;
            default: ;
        endcase
    end

    a_r8_kick_runs: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (state == ST_RUN && cnt == '0));
    a_r6_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !expired);
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !kick) |=> (state == ST_HOLD && $stable(cnt)));
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(running && expired));
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> ({1'b0, cnt} < term_eff));
endmodule

// File: rtl/an_cfg_link_timer.sv
module an_cfg_link_timer
    import an_timer_pkg::*;
#(
    parameter int unsigned CLK_MHZ = 125,
    parameter int unsigned CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_basex,
    input  logic             side_phy,
    input  logic             restart,
    input  logic             cnt_ovr_en,
    input  logic [CNT_W-1:0] cnt_ovr_val,
    output logic [15:0]      cfg_word,
    output logic             tmr_expired,
    output logic             tmr_running
);
    localparam int unsigned  T_BASEX_I = units_for(BASEX_US, CLK_MHZ);
    localparam int unsigned  T_SGMII_I = units_for(SGMII_US, CLK_MHZ);
    localparam logic [CNT_W-1:0] T_BASEX = CNT_W'(T_BASEX_I);
    localparam logic [CNT_W-1:0] T_SGMII = CNT_W'(T_SGMII_I);

    logic [1:0]       mode_q;
    logic             mode_vld;
    logic             kick;
    logic             tick;
    logic [CNT_W-1:0] term;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= 2'b00;
            mode_vld <= 1'b0;
        end else begin
            mode_q   <= {mode_basex, side_phy};
            mode_vld <= 1'b1;
        end
    end

    assign kick = restart || (mode_vld && (mode_q != {mode_basex, side_phy}));

    always_comb begin
        if (cnt_ovr_en)      term = cnt_ovr_val;
        else if (mode_basex) term = T_BASEX;
        else                 term = T_SGMII;
    end

    an_cfg_word_sel u_word (
        .mode_basex (mode_basex),
        .side_phy   (side_phy),
        .word       (cfg_word)
    );

    an_prescaler #(.PW(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (kick),
        .run   (tmr_running),
        .tick  (tick)
    );

    an_timer_fsm #(.CW(CNT_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .kick    (kick),
        .tick    (tick),
        .term    (term),
        .running (tmr_running),
        .expired (tmr_expired)
    );

    a_r9_mode_change_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_vld && (mode_q != {mode_basex, side_phy})) |=> tmr_running);
    a_r2_mac_word: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_basex && !side_phy) |-> (cfg_word == 16'h4001));
    a_r6_expiry_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_expired && !kick) |=> (!tmr_running && !tmr_expired));
endmodule

// File: tb/tb_an_cfg_link_timer.sv
module tb_an_cfg_link_timer;
    localparam int CLK_PERIOD = 10;
    localparam int MHZ        = 4;
    localparam int CW         = 16;
    localparam int T_BX       = (10000 * MHZ) >> 10;
    localparam int T_SG       = (1600 * MHZ) >> 10;
    localparam int WD_LIMIT   = 150000;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          mode_basex = 0;
    logic          side_phy = 0;
    logic          restart = 0;
    logic          cnt_ovr_en = 0;
    logic [CW-1:0] cnt_ovr_val = '0;
    logic [15:0]   cfg_word;
    logic          tmr_expired;
    logic          tmr_running;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int exp_q[$];
    bit done = 0;

    an_cfg_link_timer #(.CLK_MHZ(MHZ), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .mode_basex(mode_basex), .side_phy(side_phy),
        .restart(restart), .cnt_ovr_en(cnt_ovr_en), .cnt_ovr_val(cnt_ovr_val),
        .cfg_word(cfg_word), .tmr_expired(tmr_expired), .tmr_running(tmr_running)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, expv, expv);
        end
    endtask

    function automatic int cur_term();
        if (cnt_ovr_en) return (cnt_ovr_val == 0) ? 1 : int'(cnt_ovr_val);
        return mode_basex ? T_BX : T_SG;
    endfunction

    // driver: push the expected expiry edge for the kick about to be captured
    task automatic push_expect();
        int e;
        e = cyc + 1;
        exp_q.delete();
        exp_q.push_back(e + 1024 * cur_term());
    endtask

    task automatic do_restart();
        @(negedge clk);
        restart = 1;
        push_expect();
        @(negedge clk);
        restart = 0;
    endtask

    task automatic set_mode(input bit bx, input bit ph);
        @(negedge clk);
        mode_basex = bx;
        side_phy = ph;
        push_expect();
        #1;
    endtask

    task automatic wait_drain(input int extra);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (extra) @(negedge clk);
    endtask

    // monitor: compare each pulse against the head of the queue
    always @(negedge clk) begin
        if (rst_n && tmr_expired) begin
            if (exp_q.size() == 0) begin
                check(0, "R6 unexpected pulse", cyc, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(cyc == e, "R4/R5 expiry edge", cyc, e);
            end
        end
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            check(0, "watchdog", cyc, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: idle after reset
        check(tmr_running == 0, "R10 running after reset", tmr_running, 0);
        check(tmr_expired == 0, "R10 expired after reset", tmr_expired, 0);
        rst_n = 1;
        repeat (20) @(negedge clk);
        check(tmr_running == 0, "R10 idle without kick", tmr_running, 0);
        check(cfg_word == 16'h4001, "R2 MAC word", cfg_word, 16'h4001);

        // R3 word, then let the mode-change kick finish (R9, SGMII T)
        set_mode(0, 1);
        check(cfg_word == 16'h9801, "R3 PHY word", cfg_word, 16'h9801);
        @(negedge clk);
        check(tmr_running == 1, "R9 mode change starts timer", tmr_running, 1);
        wait_drain(0);
        @(negedge clk);
        check(tmr_running == 0 && tmr_expired == 0, "R6 after pulse", {tmr_running, tmr_expired}, 0);
        repeat (3000) @(negedge clk);
        check(tmr_running == 0, "R6 held without restart", tmr_running, 0);

        // R1 with both side values
        set_mode(1, 0);
        check(cfg_word == 16'h01E0, "R1 basex word side0", cfg_word, 16'h01E0);
        set_mode(1, 1);
        check(cfg_word == 16'h01E0, "R1 basex word side1", cfg_word, 16'h01E0);
        // R4: default 1000BASE-X interval from the last kick
        wait_drain(2);

        // R5: override value 3
        cnt_ovr_en = 1; cnt_ovr_val = 3;
        do_restart();
        repeat (1000) @(negedge clk);
        check(tmr_running == 1, "R7 running mid interval", tmr_running, 1);
        wait_drain(2);

        // R8: restart mid run
        do_restart();
        repeat (1500) @(negedge clk);
        do_restart();
        repeat (2000) @(negedge clk);
        check(tmr_expired == 0 && tmr_running == 1, "R8 old interval discarded", {tmr_running, tmr_expired}, 2);
        wait_drain(2);

        // R9: mode change during a run re-arms
        do_restart();
        repeat (2000) @(negedge clk);
        set_mode(0, 0);
        check(cfg_word == 16'h4001, "R2 MAC word again", cfg_word, 16'h4001);
        wait_drain(2);

        // R5: override of zero behaves as one unit
        cnt_ovr_val = 0;
        do_restart();
        wait_drain(2);

        // R6: no pulse during a long hold
        repeat (5000) @(negedge clk);
        check(exp_q.size() == 0 && tmr_running == 0, "R6 hold quiet", tmr_running, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule